// File: doc/BRIEF.md
# Constant Multiplier by ln 2 with Floating-Point Output

This block forms the product of a small signed integer and the natural logarithm of two and returns it as an IEEE-754 single-precision value. It serves as the exponent term of a logarithm datapath: once an argument has been split into exponent and mantissa, the exponent times ln 2 is added to the logarithm of the mantissa.

The block does not use a general multiplier. The integer is split into a signed upper slice and an unsigned 4-bit lower slice. Each slice selects an entry from a small table of ln 2 multiples, and the tables are built at elaboration by constant functions. The two entries are added as two's-complement fixed-point numbers. The sum is converted to sign-magnitude, normalised with a leading-zero count and a short left shift, and rounded to nearest even. The work runs in three pipeline stages (lookup, add, normalise-and-round), and the block accepts one operand per cycle.

Top module: `ln2_kcm_mul`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high exactly three rising edges later. `out_valid` is never high without such an input.
- R2: An operand of zero produces the bit pattern 32'h00000000 (positive zero).
- R3: For a non-zero operand, bit 31 of `out_float` is 1 exactly when the operand is negative.
- R4: For a non-zero operand, the exponent field `out_float[30:23]` lies between 126 and 125+EW inclusive, so the normalising left shift never exceeds EW-1 places.
- R5: `out_float` equals the exact product operand·ln 2 rounded to single precision with round-to-nearest-even, which keeps it within half an ulp. For example, operand 1 gives 32'h3F317218.
- R6: After reset `out_float` is 32'h00000000. While `out_valid` is low, `out_float` keeps the last result.
- R7: For any operand e with -e representable, the results for e and -e differ only in bit 31.
- R8: A new operand is accepted on every cycle. Back-to-back operands give back-to-back results in input order.
- R9: `in_exp` has no effect while `in_valid` is low: no result appears and `out_float` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies `in_exp` for this cycle |
| in_exp | input | EW | Signed two's-complement operand |
| out_valid | output | 1 | High for one cycle per result |
| out_float | output | 32 | Single-precision product, held between results |

## Verification
On every cycle the assertions check the three-cycle valid latency, the zero encoding, the sign bit, the exponent window, the bound on the normaliser shift, and that the output holds between results. Bit-exact rounding can only be shown by the bench's scenarios, as can the sign symmetry and the output order under back-to-back input. The bench sweeps every legal operand and compares each result against an independent high-precision integer computation.

// File: rtl/ln2_kcm_pkg.sv
package ln2_kcm_pkg;

  // ln 2 scaled by 2^64, truncated
  localparam logic [63:0] LN2_Q64 = 64'hB17217F7D1CF79AB;

  localparam int FLT_BIAS = 127;
  localparam int MANT_W   = 24;

  // k * ln2 with fb fraction bits, two's complement, modulo 2^128
  function automatic logic [127:0] ln2_multiple(input longint k, input int fb);
    logic [127:0] c;
    logic [127:0] kk;
    c  = {64'd0, LN2_Q64 >> (64 - fb)};
    kk = {{64{k[63]}}, k};
    return kk * c;
  endfunction

endpackage

// File: rtl/ln2_kcm_table.sv
module ln2_kcm_table
  import ln2_kcm_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int SW         = 64,
  parameter int FB         = 56,
  parameter int SCALE_SH   = 0,
  parameter bit SIGNED_IDX = 1'b0
) (
  input  logic [IDX_W-1:0] idx,
  output logic [SW-1:0]    entry
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int HALF    = ENTRIES / 2;

  logic [SW-1:0] tab [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_row
    localparam longint KV = (SIGNED_IDX && g >= HALF) ? longint'(g) - longint'(ENTRIES)
                                                      : longint'(g);
    localparam logic [127:0] FULL = ln2_multiple(KV * (longint'(1) <<< SCALE_SH), FB);
    assign tab[g] = FULL[SW-1:0];
  end

  assign entry = tab[idx];
endmodule

// File: rtl/ln2_kcm_norm.sv
module ln2_kcm_norm
  import ln2_kcm_pkg::*;
#(
  parameter int SW  = 64,
  parameter int FB  = 56,
  parameter int SHW = 6
) (
  input  logic [SW-1:0]  sum,
  output logic [31:0]    flt,
  output logic [SHW-1:0] shift_amt,
  output logic           is_zero
);
  localparam int MW       = SW - 1;
  localparam int EXP_TOP  = FLT_BIAS + MW - 1 - FB;
  localparam int GRD      = MW - MANT_W - 1;

  logic          neg;
  logic [SW-1:0] mag_full;
  logic [MW-1:0] mag;
  logic [MW-1:0] nrm;
  logic [MANT_W-1:0] mant;
  logic          guard_b;
  logic          sticky;
  logic          rnd_up;
  logic [MANT_W:0] mant_r;
  logic [9:0]    ex;
  logic [22:0]   frac;

  assign neg      = sum[SW-1];
  assign mag_full = neg ? (~sum + 1'b1) : sum;
  assign mag      = mag_full[MW-1:0];
  assign is_zero  = (mag == '0);

  always_comb begin
    shift_amt = '0;
    for (int i = 0; i < MW; i++) begin
      if (mag[i]) shift_amt = SHW'(MW - 1 - i);
    end
  end

  assign nrm     = mag << shift_amt;
  assign mant    = nrm[MW-1 -: MANT_W];
  assign guard_b = nrm[GRD];
  assign sticky  = |nrm[GRD-1:0];
  assign rnd_up  = guard_b & (sticky | mant[0]);
  assign mant_r  = {1'b0, mant} + {{MANT_W{1'b0}}, rnd_up};
  assign ex      = 10'(EXP_TOP) - 10'(shift_amt) + {9'd0, mant_r[MANT_W]};
  assign frac    = mant_r[MANT_W] ? 23'd0 : mant_r[22:0];
  assign flt     = is_zero ? 32'h0 : {neg, ex[7:0], frac};
endmodule

// File: rtl/ln2_kcm_mul.sv
module ln2_kcm_mul
  import ln2_kcm_pkg::*;
#(
  parameter int EW = 8,
  parameter int FB = 56
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [EW-1:0] in_exp,
  output logic          out_valid,
  output logic [31:0]   out_float
);
  localparam int LO_W = 4;
  localparam int HI_W = EW - LO_W;
  localparam int SW   = EW + FB;
  localparam int SHW  = $clog2(SW);

  logic [SW-1:0] lo_ent, hi_ent;
  logic [SW-1:0] lo_q, hi_q, sum_q;
  logic          v1_q, v2_q;
  logic [31:0]   norm_flt;
  logic [SHW-1:0] norm_shift;
  logic          norm_zero;

  ln2_kcm_table #(.IDX_W(LO_W), .SW(SW), .FB(FB), .SCALE_SH(0), .SIGNED_IDX(1'b0)) u_lo_tab (
    .idx(in_exp[LO_W-1:0]), .entry(lo_ent));

  ln2_kcm_table #(.IDX_W(HI_W), .SW(SW), .FB(FB), .SCALE_SH(LO_W), .SIGNED_IDX(1'b1)) u_hi_tab (
    .idx(in_exp[EW-1:LO_W]), .entry(hi_ent));

  // stage 1: lookup
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) begin
        lo_q <= lo_ent;
        hi_q <= hi_ent;
      end
    end
  end

  // stage 2: integer add
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2_q  <= 1'b0;
      sum_q <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) sum_q <= lo_q + hi_q;
    end
  end

  ln2_kcm_norm #(.SW(SW), .FB(FB), .SHW(SHW)) u_norm (
    .sum(sum_q), .flt(norm_flt), .shift_amt(norm_shift), .is_zero(norm_zero));

  // stage 3: normalise and round
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_float <= 32'h0;
    end else begin
      out_valid <= v2_q;
      if (v2_q) out_float <= norm_flt;
    end
  end
endmodule

// File: rtl/ln2_kcm_chk.sv
module ln2_kcm_chk #(
  parameter int EW  = 8,
  parameter int SHW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [EW-1:0]  in_exp,
  input logic           out_valid,
  input logic [31:0]    out_float,
  input logic           s2_valid,
  input logic           s2_zero,
  input logic [SHW-1:0] norm_shift
);
  localparam int EXP_MIN = 126;
  localparam int EXP_MAX = 125 + EW;

  logic [2:0] vp, zp, sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp <= '0;
      zp <= '0;
      sp <= '0;
    end else begin
      vp <= {vp[1:0], in_valid};
      zp <= {zp[1:0], (in_exp == '0)};
      sp <= {sp[1:0], in_exp[EW-1]};
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vp[2]);

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zp[2]) |-> (out_float == 32'h0));

  p_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !zp[2]) |-> (out_float[31] == sp[2]));

  p_exp_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !zp[2]) |-> (out_float[30:23] >= 8'(EXP_MIN) && out_float[30:23] <= 8'(EXP_MAX)));

  p_shift_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && !s2_zero) |-> (int'(norm_shift) <= EW - 1));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_float));
endmodule

bind ln2_kcm_mul ln2_kcm_chk #(.EW(EW), .SHW(SHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_exp(in_exp),
  .out_valid(out_valid), .out_float(out_float),
  .s2_valid(v2_q), .s2_zero(norm_zero), .norm_shift(norm_shift));

// File: tb/ln2_kcm_mul_test.sv
`timescale 1ns/1ps
module ln2_kcm_mul_test;
  localparam int EW = 8;
  localparam int NV = 1 << EW;
  localparam logic [63:0] LN2_FRAC = 64'hB17217F7D1CF79AB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [EW-1:0] in_exp = '0;
  logic          out_valid;
  logic [31:0]   out_float;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int seen_valid = 0;
  bit done = 1'b0;

  bit          pv [3];
  int          pe [3];
  logic [31:0] last_exp = 32'h0;
  logic [31:0] res [NV];

  ln2_kcm_mul #(.EW(EW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_exp(in_exp),
    .out_valid(out_valid), .out_float(out_float));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycles=%0d expected completion", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] ref_float(int e);
    logic [127:0] mag, rem, half;
    logic [24:0]  mant;
    longint       ae;
    int           pos, sh, ex;
    if (e == 0) return 32'h0;
    ae  = (e < 0) ? -longint'(e) : longint'(e);
    mag = 128'(ae) * {64'd0, LN2_FRAC};
    pos = 0;
    for (int i = 0; i < 128; i++) if (mag[i]) pos = i;
    ex   = pos - 64 + 127;
    sh   = pos - 23;
    mant = 25'(mag >> sh);
    rem  = mag & ((128'd1 << sh) - 128'd1);
    half = 128'd1 << (sh - 1);
    if (rem > half || (rem == half && mant[0])) mant = mant + 25'd1;
    if (mant[24]) begin
      mant = mant >> 1;
      ex   = ex + 1;
    end
    return {(e < 0) ? 1'b1 : 1'b0, 8'(ex), mant[22:0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp_v);
    checks = checks + 1;
    if (act !== exp_v) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // one cycle: advance the model, compare, then drive the next input
  task automatic step(bit v, int e, string idle_tag);
    bit mv;
    int me;
    @(negedge clk);
    mv = pv[2];
    me = pe[2];
    pv[2] = pv[1]; pe[2] = pe[1];
    pv[1] = pv[0]; pe[1] = pe[0];
    pv[0] = v;     pe[0] = e;
    if (mv) last_exp = ref_float(me);
    check(mv ? "R1" : idle_tag, {31'd0, out_valid}, {31'd0, mv});
    check(mv ? ((me == 0) ? "R2" : "R5") : "R6", out_float, last_exp);
    if (mv) begin
      res[me + NV/2] = out_float;
      seen_valid = seen_valid + 1;
    end
    in_valid = v;
    in_exp   = e[EW-1:0];
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pe[i] = 0; end
    for (int i = 0; i < NV; i++) res[i] = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    // reset state (R6, R1)
    check("R6", out_float, 32'h0);
    check("R1", {31'd0, out_valid}, 32'd0);
    rst_n = 1'b1;

    // R8: every operand back to back, most negative first
    seen_valid = 0;
    for (int e = -NV/2; e < NV/2; e++) step(1'b1, e, "R1");
    for (int k = 0; k < 4; k++) step(1'b0, 0, "R1");
    check("R8", 32'(seen_valid), 32'(NV));

    // R9: junk operands with in_valid low
    for (int k = 0; k < 8; k++) step(1'b0, (k * 37) - 100, "R9");

    // R2, R5: sparse operands with gaps, boundaries included
    step(1'b1, 1, "R1");    step(1'b0, 5, "R9");
    step(1'b1, -1, "R1");   step(1'b0, 0, "R9");
    step(1'b1, 0, "R1");    step(1'b0, -3, "R9");
    step(1'b1, NV/2 - 1, "R1"); step(1'b0, 0, "R9");
    step(1'b1, -NV/2, "R1");    step(1'b1, 16, "R1");
    step(1'b1, -17, "R1");  step(1'b0, 0, "R9");
    for (int k = 0; k < 5; k++) step(1'b0, 0, "R9");

    check("R5", res[NV/2 + 1], 32'h3F317218);
    check("R5", res[NV/2 - 1], 32'hBF317218);
    check("R2", res[NV/2], 32'h0);

    // R3, R4: sign and exponent window over all non-zero operands
    for (int e = -NV/2; e < NV/2; e++) begin
      if (e != 0) begin
        check("R3", {31'd0, res[e + NV/2][31]}, {31'd0, (e < 0) ? 1'b1 : 1'b0});
        checks = checks + 1;
        if (res[e + NV/2][30:23] < 8'd126 || res[e + NV/2][30:23] > 8'(125 + EW)) begin
          errors = errors + 1;
          $display("FAIL R4: actual=%0d expected=126..%0d", res[e + NV/2][30:23], 125 + EW);
        end
      end
    end

    // R7: symmetry
    for (int e = 1; e < NV/2; e++)
      check("R7", res[NV/2 + e] ^ res[NV/2 - e], 32'h80000000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule